// File: doc/BRIEF.md
# Highway and Farm Road Crossing Light Sequencer

This block sequences the lights at a crossing where a busy highway meets a quiet farm road. It is a Moore machine with four phases: highway green, highway amber, farm green and farm amber. It visits them in that fixed loop. The highway keeps its green until a vehicle waits on the farm road and a long interval has run out. Amber phases always last one short interval. The farm road keeps its green only while vehicles are present and the long interval has not expired.

An external interval timer supplies the short and long expiry flags. The block sends it a one-cycle restart pulse whenever the phase changes. Each road receives a 2-bit lamp code. A parameter picks how the phase is held internally: a dense 2-bit code or a one-hot 4-bit vector. Both choices give the same behaviour at the ports. A one-hot vector that is damaged returns to highway green on the next clock.

Top module: `tlc_top`

## Requirements
- R1: While `rst_n` is low, without waiting for a clock, the outputs show highway green with farm red and `tmr_restart` is low.
- R2: Lamp codes are green = 2'b00, amber = 2'b01, red = 2'b10, and 2'b11 never appears. The phases show (highway, farm) as: highway green (00,10), highway amber (01,10), farm green (10,00), farm amber (10,01). At least one road always shows red.
- R3: From highway green, the machine moves to highway amber at the next clock only when `car_sense` and `tmr_long` are both high. With any other input it stays, and `tmr_short` is ignored.
- R4: From highway amber, the machine moves to farm green on `tmr_short`. Otherwise it stays, whatever `car_sense` and `tmr_long` are.
- R5: From farm green, the machine moves to farm amber when `car_sense` is low or `tmr_long` is high. Otherwise it stays, and `tmr_short` is ignored.
- R6: From farm amber, the machine moves to highway green on `tmr_short` and otherwise stays.
- R7: `tmr_restart` is high for exactly the first cycle that shows a new phase. In every other cycle it is low.
- R8: The dense (`ONE_HOT` = 0) and one-hot (`ONE_HOT` = 1) builds give identical port outputs for identical input sequences.
- R9: The release of `rst_n` is synchronised. The phase is held through the first two rising clock edges after `rst_n` goes high, and it can first change on the third.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released through a synchroniser |
| car_sense | input | 1 | High while a vehicle waits on the farm road |
| tmr_short | input | 1 | Short interval expired |
| tmr_long | input | 1 | Long interval expired |
| tmr_restart | output | 1 | One-cycle pulse telling the timer to start a new interval |
| hwy_light | output | 2 | Highway lamp code |
| farm_light | output | 2 | Farm road lamp code |

## Verification
A wrong internal phase appears at the lamp outputs in the cycle after the faulty edge, because the lamps are decoded directly from the state register. A missing or extra restart pulse appears in that same cycle. Running the two encodings side by side against a reference model of the phase loop catches any divergence within one clock. Directed rows hold each phase under inputs that must be ignored, so that a transition taken early is exposed at once.

// File: rtl/tlc_pkg.sv
package tlc_pkg;

  typedef enum logic [1:0] {
    LAMP_GREEN = 2'b00,
    LAMP_AMBER = 2'b01,
    LAMP_RED   = 2'b10
  } lamp_e;

  typedef enum logic [1:0] {
    PH_HWY_GO,
    PH_HWY_WARN,
    PH_FARM_GO,
    PH_FARM_WARN
  } phase_e;

  localparam int NUM_PHASES = 4;
  localparam int DENSE_W    = $clog2(NUM_PHASES);

endpackage

// File: rtl/tlc_rst_sync.sv
module tlc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/tlc_state_reg.sv
module tlc_state_reg
  import tlc_pkg::*;
#(
  parameter bit ONE_HOT = 1'b0
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   car_sense,
  input  logic   tmr_short,
  input  logic   tmr_long,
  output phase_e phase,
  output logic   moved
);
  logic hwy_leave;
  logic farm_leave;

  assign hwy_leave  = car_sense & tmr_long;
  assign farm_leave = ~car_sense | tmr_long;

  if (ONE_HOT) begin : g_onehot
    localparam int W = NUM_PHASES;
    localparam logic [W-1:0] HOME = W'(1);
    logic [W-1:0] st_q, st_d;
    logic         legal;
    logic         upd;

    always_comb begin
      legal = (st_q != '0) && ((st_q & (st_q - W'(1))) == '0);
      st_d[0] = (st_q[0] & ~hwy_leave)  | (st_q[3] & tmr_short);
      st_d[1] = (st_q[0] & hwy_leave)   | (st_q[1] & ~tmr_short);
      st_d[2] = (st_q[1] & tmr_short)   | (st_q[2] & ~farm_leave);
      st_d[3] = (st_q[2] & farm_leave)  | (st_q[3] & ~tmr_short);
      if (!legal) st_d = HOME;
      upd = (st_d != st_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   st_q <= HOME;
      else if (upd) st_q <= st_d;
    end

    always_comb begin
      if (st_q[1])      phase = PH_HWY_WARN;
      else if (st_q[2]) phase = PH_FARM_GO;
      else if (st_q[3]) phase = PH_FARM_WARN;
      else              phase = PH_HWY_GO;
    end

    assign moved = upd;
  end else begin : g_dense
    localparam logic [DENSE_W-1:0] C_HWY_GO    = 2'b00;
    localparam logic [DENSE_W-1:0] C_HWY_WARN  = 2'b10;
    localparam logic [DENSE_W-1:0] C_FARM_GO   = 2'b01;
    localparam logic [DENSE_W-1:0] C_FARM_WARN = 2'b11;
    logic [DENSE_W-1:0] st_q, st_d;
    logic               upd;

    always_comb begin
      st_d = st_q;
      case (st_q)
        C_HWY_GO:    if (hwy_leave)  st_d = C_HWY_WARN;
        C_HWY_WARN:  if (tmr_short)  st_d = C_FARM_GO;
        C_FARM_GO:   if (farm_leave) st_d = C_FARM_WARN;
        C_FARM_WARN: if (tmr_short)  st_d = C_HWY_GO;
        default:                     st_d = C_HWY_GO;
      endcase
      upd = (st_d != st_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   st_q <= C_HWY_GO;
      else if (upd) st_q <= st_d;
    end

    always_comb begin
      case (st_q)
        C_HWY_WARN:  phase = PH_HWY_WARN;
        C_FARM_GO:   phase = PH_FARM_GO;
        C_FARM_WARN: phase = PH_FARM_WARN;
        default:     phase = PH_HWY_GO;
      endcase
    end

    assign moved = upd;
  end
endmodule

// File: rtl/tlc_out_stage.sv
module tlc_out_stage
  import tlc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  phase_e     phase,
  input  logic       moved,
  output logic       tmr_restart,
  output logic [1:0] hwy_light,
  output logic [1:0] farm_light
);
  lamp_e hwy_l, farm_l;
  logic  restart_q;

  always_comb begin
    case (phase)
      PH_HWY_WARN:  begin hwy_l = LAMP_AMBER; farm_l = LAMP_RED;   end
      PH_FARM_GO:   begin hwy_l = LAMP_RED;   farm_l = LAMP_GREEN; end
      PH_FARM_WARN: begin hwy_l = LAMP_RED;   farm_l = LAMP_AMBER; end
      default:      begin hwy_l = LAMP_GREEN; farm_l = LAMP_RED;   end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) restart_q <= 1'b0;
    else        restart_q <= moved;
  end

  assign tmr_restart = restart_q;
  assign hwy_light   = hwy_l;
  assign farm_light  = farm_l;
endmodule

// File: rtl/tlc_top.sv
module tlc_top
  import tlc_pkg::*;
#(
  parameter bit ONE_HOT     = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       car_sense,
  input  logic       tmr_short,
  input  logic       tmr_long,
  output logic       tmr_restart,
  output logic [1:0] hwy_light,
  output logic [1:0] farm_light
);
  logic   rst_sync_n;
  phase_e phase;
  logic   moved;

  tlc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tlc_state_reg #(.ONE_HOT(ONE_HOT)) u_state (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .car_sense (car_sense),
    .tmr_short (tmr_short),
    .tmr_long  (tmr_long),
    .phase     (phase),
    .moved     (moved)
  );

  tlc_out_stage u_out (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .phase       (phase),
    .moved       (moved),
    .tmr_restart (tmr_restart),
    .hwy_light   (hwy_light),
    .farm_light  (farm_light)
  );
endmodule

// File: rtl/tlc_checker.sv
module tlc_checker
  import tlc_pkg::*;
(
  input logic       clk,
  input logic       rst_ok,
  input logic       car_sense,
  input logic       tmr_short,
  input logic       tmr_long,
  input logic       tmr_restart,
  input logic [1:0] hwy_light,
  input logic [1:0] farm_light
);
  logic hg, hy, fg, fy;
  assign hg = (hwy_light == LAMP_GREEN);
  assign hy = (hwy_light == LAMP_AMBER);
  assign fg = (farm_light == LAMP_GREEN);
  assign fy = (farm_light == LAMP_AMBER);

  AST_LAMP_CODE: assert property (@(posedge clk) disable iff (!rst_ok)
    (hwy_light != 2'b11) && (farm_light != 2'b11)); // R2
  AST_ONE_RED: assert property (@(posedge clk) disable iff (!rst_ok)
    (hwy_light == LAMP_RED) || (farm_light == LAMP_RED)); // R2
  AST_HWY_LEAVE: assert property (@(posedge clk) disable iff (!rst_ok)
    hg && car_sense && tmr_long |=> hy); // R3
  AST_HWY_HOLD: assert property (@(posedge clk) disable iff (!rst_ok)
    hg && !(car_sense && tmr_long) |=> hg); // R3
  AST_AMBER_HWY: assert property (@(posedge clk) disable iff (!rst_ok)
    hy && tmr_short |=> fg); // R4
  AST_FARM_LEAVE: assert property (@(posedge clk) disable iff (!rst_ok)
    fg && (!car_sense || tmr_long) |=> fy); // R5
  AST_AMBER_FARM: assert property (@(posedge clk) disable iff (!rst_ok)
    fy && tmr_short |=> hg); // R6
  AST_PULSE_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_ok)
    tmr_restart |-> !($stable(hwy_light) && $stable(farm_light))); // R7
  AST_CHANGE_HAS_PULSE: assert property (@(posedge clk) disable iff (!rst_ok)
    !($stable(hwy_light) && $stable(farm_light)) |-> tmr_restart); // R7
endmodule

bind tlc_top tlc_checker u_chk (
  .clk         (clk),
  .rst_ok      (rst_sync_n),
  .car_sense   (car_sense),
  .tmr_short   (tmr_short),
  .tmr_long    (tmr_long),
  .tmr_restart (tmr_restart),
  .hwy_light   (hwy_light),
  .farm_light  (farm_light)
);

// File: tb/tlc_top_bench.sv
`timescale 1ns/1ps
module tlc_top_bench;
  logic clk = 1'b0;
  logic rst_n, car, tshort, tlong;
  logic       rs_d, rs_o;
  logic [1:0] hw_d, fm_d, hw_o, fm_o;
  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  tlc_top #(.ONE_HOT(1'b0)) u_tlc_top (
    .clk(clk), .rst_n(rst_n), .car_sense(car), .tmr_short(tshort), .tmr_long(tlong),
    .tmr_restart(rs_d), .hwy_light(hw_d), .farm_light(fm_d));

  tlc_top #(.ONE_HOT(1'b1)) u_tlc_top_oh (
    .clk(clk), .rst_n(rst_n), .car_sense(car), .tmr_short(tshort), .tmr_long(tlong),
    .tmr_restart(rs_o), .hwy_light(hw_o), .farm_light(fm_o));

  // row: {car, short, long, restart, hwy[1:0], farm[1:0]} ; expected after one edge
  localparam logic [7:0] VEC [17] = '{
    8'b001_0_00_10, // R3 long alone: stay
    8'b100_0_00_10, // R3 car alone: stay
    8'b010_0_00_10, // R3 short ignored
    8'b101_1_01_10, // R3 leave to highway amber
    8'b000_0_01_10, // R4 hold
    8'b101_0_01_10, // R4 car+long ignored
    8'b010_1_10_00, // R4 to farm green
    8'b100_0_10_00, // R5 car present: stay
    8'b110_0_10_00, // R5 short ignored
    8'b101_1_10_01, // R5 long expiry
    8'b000_0_10_01, // R6 hold
    8'b010_1_00_10, // R6 back to highway green
    8'b101_1_01_10, // R3
    8'b010_1_10_00, // R4
    8'b000_1_10_01, // R5 no car
    8'b111_1_00_10, // R6
    8'b000_0_00_10  // R7 no pulse on hold
  };

  task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [3:0] lamps(input int ph);
    case (ph)
      1: return 4'b01_10;
      2: return 4'b10_00;
      3: return 4'b10_01;
      default: return 4'b00_10;
    endcase
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int m;
    int nx;
    rst_n = 1'b0; car = 1'b0; tshort = 1'b0; tlong = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) step();
    chk("R1 reset state dense", {rs_d, hw_d, fm_d}, 5'b0_00_10);
    chk("R1 reset state onehot", {rs_o, hw_o, fm_o}, 5'b0_00_10);

    for (int i = 0; i < 17; i++) begin
      @(negedge clk);
      {car, tshort, tlong} = VEC[i][7:5];
      step();
      chk($sformatf("R2-table row %0d dense", i), {rs_d, hw_d, fm_d}, VEC[i][4:0]);
      chk($sformatf("R8 row %0d onehot", i), {rs_o, hw_o, fm_o}, VEC[i][4:0]);
    end

    // move to highway amber, then reset asynchronously
    @(negedge clk);
    {car, tshort, tlong} = 3'b101;
    step();
    chk("R3 pre-reset move", {rs_d, hw_d, fm_d}, 5'b1_01_10);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset dense", {rs_d, hw_d, fm_d}, 5'b0_00_10);
    chk("R1 async reset onehot", {rs_o, hw_o, fm_o}, 5'b0_00_10);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    step();
    chk("R9 edge1 held", {rs_d, hw_d, fm_d}, 5'b0_00_10);
    step();
    chk("R9 edge2 held", {rs_o, hw_o, fm_o}, 5'b0_00_10);
    step();
    chk("R9 edge3 moves dense", {rs_d, hw_d, fm_d}, 5'b1_01_10);
    chk("R9 edge3 moves onehot", {rs_o, hw_o, fm_o}, 5'b1_01_10);
    m = 1;

    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      car    = ($urandom_range(0, 3) != 0);
      tshort = ($urandom_range(0, 2) == 0);
      tlong  = ($urandom_range(0, 3) == 0);
      case (m)
        0: nx = (car && tlong) ? 1 : 0;
        1: nx = tshort ? 2 : 1;
        2: nx = (!car || tlong) ? 3 : 2;
        default: nx = tshort ? 0 : 3;
      endcase
      step();
      chk("R7 random dense", {rs_d, hw_d, fm_d}, {logic'(nx != m), lamps(nx)});
      chk("R8 random lockstep", {rs_o, hw_o, fm_o}, {rs_d, hw_d, fm_d});
      m = nx;
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule